// File: doc/BRIEF.md
# Fixed-Priority Serial Port Byte Collector

The collector sits between 32 serial receive ports and a downstream line processor. Each port deposits a received byte into its own holding slot, along with the time slot that byte arrived in. It then raises a pending flag. On every clock cycle in which the downstream side is ready, the collector takes at most one pending byte. When several ports have a byte waiting, the port with the lowest number always wins.

The winning port number and time slot together address a programmable channel map. Each map entry gives a logical channel number, a channel type and an enable bit. The byte leaves the block with its channel number and type so the downstream processor knows how to treat it. A byte whose map entry is disabled is discarded and counted instead of being forwarded. Software or a configuration engine fills the map through a simple synchronous write port.

Top module: `port_byte_collector`

## Requirements
- R1: While reset is high and on the first cycle after it, `out_valid` is 0 and `drop_count` is 0. Every pending flag is cleared by reset, so a byte loaded before reset is never forwarded afterwards. The map contents are not affected by reset.
- R2: When `port_load[p]` is high at a rising edge, the slot of port p captures its byte and time slot. With `out_ready` held high and no other port pending, that byte appears on `out_byte` with `out_valid` high after the second following rising edge, and `out_valid` stays high for exactly one cycle.
- R3: At most one byte is taken per clock. Among pending ports the lowest-numbered one is taken first, so simultaneous bytes on ports 3, 7 and 20 come out on three consecutive cycles in the order 3, 7, 20.
- R4: A forwarded byte carries `out_port` and `out_ts` of its source. It also carries `out_chan` and `out_ctype` read from the map entry at address {port[4:0], timeslot[4:0]}, with the port in the upper five bits. A map entry is 8 bits: bit 7 is enable, bits 6:5 are the channel type, and bits 4:0 are the channel number.
- R5: A byte whose map entry has bit 7 equal to 0 does not raise `out_valid`. Instead `drop_count` rises by exactly one, on the same edge at which the byte would have appeared on the output.
- R6: While `out_ready` is low, no port is taken, no pending flag is cleared, and a valid output holds its value unchanged. When `out_ready` returns high, held and pending bytes flow on with no byte lost.
- R7: A load to a port that is already pending replaces the held byte, and only the newest byte is forwarded. A load arriving on the same edge at which the port is taken leaves the new byte pending, so it is forwarded on the next cycle.
- R8: A map write (`map_we` high at a rising edge) replaces the entry at `map_addr`. Bytes taken afterwards use the new entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| port_load | input | 32 | One strobe per port: capture a new byte |
| port_data | input | 256 | Byte for port p at bits [8p+7:8p] |
| port_ts | input | 160 | Time slot for port p at bits [5p+4:5p] |
| map_we | input | 1 | Channel map write enable |
| map_addr | input | 10 | Map write address {port, timeslot} |
| map_wdata | input | 8 | Map entry {enable, type[1:0], channel[4:0]} |
| out_ready | input | 1 | Downstream can accept a byte |
| out_valid | output | 1 | Output byte is valid |
| out_byte | output | 8 | Forwarded byte |
| out_port | output | 5 | Source port of the byte |
| out_ts | output | 5 | Time slot of the byte |
| out_chan | output | 5 | Logical channel number from the map |
| out_ctype | output | 2 | Channel type from the map |
| drop_count | output | 16 | Number of bytes dropped on disabled channels (wraps) |

## Verification
The checker watches four properties on every cycle:
- The grant is one-hot or empty and never lands on a port while a lower-numbered port is pending.
- Nothing is granted and no flag falls while `out_ready` is low, and a stalled output does not change.
- A pending byte with the output ready always produces a grant.
- `drop_count` never steps by more than one.

The exact latency, the values read through the map, the drop decision, the replacement of a pending byte and the effect of reset on pending bytes all depend on particular load sequences and map contents. Only the bench's scenarios can show those.

// File: rtl/pbc_pkg.sv
package pbc_pkg;
  localparam int CHAN_W  = 5;
  localparam int CTYPE_W = 2;

  // one channel map word: enable on top, then type, then channel number
  typedef struct packed {
    logic               en;
    logic [CTYPE_W-1:0] ctype;
    logic [CHAN_W-1:0]  chan;
  } map_ent_t;
endpackage

// File: rtl/port_slots.sv
module port_slots #(
  parameter int NUM_PORTS = 32,
  parameter int DATA_W    = 8,
  parameter int TS_W      = 5
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [NUM_PORTS-1:0]        load,
  input  logic [NUM_PORTS*DATA_W-1:0] load_data,
  input  logic [NUM_PORTS*TS_W-1:0]   load_ts,
  input  logic [NUM_PORTS-1:0]        grant,
  output logic [NUM_PORTS-1:0]        pend,
  output logic [NUM_PORTS*DATA_W-1:0] hold_data,
  output logic [NUM_PORTS*TS_W-1:0]   hold_ts
);
  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_slot
    // a fresh load beats a grant on the same edge
    always_ff @(posedge clk) begin
      if (rst)          pend[p] <= 1'b0;
      else if (load[p]) pend[p] <= 1'b1;
      else if (grant[p]) pend[p] <= 1'b0;
    end

    always_ff @(posedge clk) begin
      if (load[p]) begin
        hold_data[p*DATA_W +: DATA_W] <= load_data[p*DATA_W +: DATA_W];
        hold_ts[p*TS_W +: TS_W]       <= load_ts[p*TS_W +: TS_W];
      end
    end
  end
endmodule

// File: rtl/prio_pick.sv
module prio_pick #(
  parameter int NUM_PORTS = 32,
  localparam int IDX_W = $clog2(NUM_PORTS)
) (
  input  logic [NUM_PORTS-1:0] req,
  input  logic                 enable,
  output logic [NUM_PORTS-1:0] grant,
  output logic [IDX_W-1:0]     idx,
  output logic                 take
);
  logic any_req;

  always_comb begin
    idx = '0;
    for (int i = NUM_PORTS - 1; i >= 0; i--) begin
      if (req[i]) idx = IDX_W'(i);
    end
  end

  assign any_req = |req;
  assign take    = any_req & enable;

  always_comb begin
    grant = '0;
    if (take) grant[idx] = 1'b1;
  end
endmodule

// File: rtl/chan_map_ram.sv
module chan_map_ram #(
  parameter int ADDR_W = 10,
  parameter int DW     = 8,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DW-1:0]     wr_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DW-1:0]     rd_data
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  // read port holds its word while not enabled
  always_ff @(posedge clk) begin
    if (rd_en) rd_data <= mem[rd_addr];
  end
endmodule

// File: rtl/port_byte_collector.sv
module port_byte_collector
  import pbc_pkg::*;
#(
  parameter int NUM_PORTS = 32,
  parameter int DATA_W    = 8,
  parameter int TS_W      = 5,
  parameter int CNT_W     = 16,
  localparam int PORT_W = $clog2(NUM_PORTS),
  localparam int MAP_AW = PORT_W + TS_W,
  localparam int ENT_W  = $bits(map_ent_t)
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [NUM_PORTS-1:0]        port_load,
  input  logic [NUM_PORTS*DATA_W-1:0] port_data,
  input  logic [NUM_PORTS*TS_W-1:0]   port_ts,
  input  logic                        map_we,
  input  logic [MAP_AW-1:0]           map_addr,
  input  logic [ENT_W-1:0]            map_wdata,
  input  logic                        out_ready,
  output logic                        out_valid,
  output logic [DATA_W-1:0]           out_byte,
  output logic [PORT_W-1:0]           out_port,
  output logic [TS_W-1:0]             out_ts,
  output logic [CHAN_W-1:0]           out_chan,
  output logic [CTYPE_W-1:0]          out_ctype,
  output logic [CNT_W-1:0]            drop_count
);
  logic [NUM_PORTS-1:0]        pend;
  logic [NUM_PORTS-1:0]        grant;
  logic [NUM_PORTS*DATA_W-1:0] hold_data;
  logic [NUM_PORTS*TS_W-1:0]   hold_ts;
  logic [PORT_W-1:0]           win_idx;
  logic                        take;
  logic [DATA_W-1:0]           win_data;
  logic [TS_W-1:0]             win_ts;
  logic [ENT_W-1:0]            ent_raw;
  map_ent_t                    ent;

  // stage 1: granted byte waiting for its map word
  logic              s1_valid;
  logic [DATA_W-1:0] s1_data;
  logic [PORT_W-1:0] s1_port;
  logic [TS_W-1:0]   s1_ts;

  port_slots #(
    .NUM_PORTS(NUM_PORTS), .DATA_W(DATA_W), .TS_W(TS_W)
  ) u_slots (
    .clk(clk), .rst(rst),
    .load(port_load), .load_data(port_data), .load_ts(port_ts),
    .grant(grant),
    .pend(pend), .hold_data(hold_data), .hold_ts(hold_ts)
  );

  prio_pick #(.NUM_PORTS(NUM_PORTS)) u_pick (
    .req(pend), .enable(out_ready),
    .grant(grant), .idx(win_idx), .take(take)
  );

  assign win_data = hold_data[int'(win_idx)*DATA_W +: DATA_W];
  assign win_ts   = hold_ts[int'(win_idx)*TS_W +: TS_W];

  chan_map_ram #(.ADDR_W(MAP_AW), .DW(ENT_W)) u_map (
    .clk(clk),
    .wr_en(map_we), .wr_addr(map_addr), .wr_data(map_wdata),
    .rd_en(take), .rd_addr({win_idx, win_ts}), .rd_data(ent_raw)
  );

  assign ent = map_ent_t'(ent_raw);

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_valid <= 1'b0;
    end else if (out_ready) begin
      s1_valid <= take;
    end
  end

  always_ff @(posedge clk) begin
    if (out_ready && take) begin
      s1_data <= win_data;
      s1_port <= win_idx;
      s1_ts   <= win_ts;
    end
  end

  // stage 2: registered output, drop on disabled channel
  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid  <= 1'b0;
      drop_count <= '0;
    end else if (out_ready) begin
      out_valid <= s1_valid & ent.en;
      if (s1_valid && !ent.en) drop_count <= drop_count + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (out_ready && s1_valid) begin
      out_byte  <= s1_data;
      out_port  <= s1_port;
      out_ts    <= s1_ts;
      out_chan  <= ent.chan;
      out_ctype <= ent.ctype;
    end
  end
endmodule

// File: rtl/pbc_chk.sv
module pbc_chk #(
  parameter int NUM_PORTS = 32,
  parameter int DATA_W    = 8,
  parameter int CNT_W     = 16,
  parameter int PORT_W    = 5,
  parameter int CHAN_W    = 5
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 out_ready,
  input logic                 out_valid,
  input logic [DATA_W-1:0]    out_byte,
  input logic [PORT_W-1:0]    out_port,
  input logic [CHAN_W-1:0]    out_chan,
  input logic [NUM_PORTS-1:0] pend,
  input logic [NUM_PORTS-1:0] grant,
  input logic [CNT_W-1:0]     drop_count
);
  localparam logic [NUM_PORTS-1:0] ONE = NUM_PORTS'(1);

  // R3
  single_grant_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(grant));

  // R3
  lowest_first_chk: assert property (@(posedge clk) disable iff (rst)
    (grant != '0) |-> ((pend & (grant - ONE)) == '0));

  // R6
  no_grant_stalled_chk: assert property (@(posedge clk) disable iff (rst)
    !out_ready |-> (grant == '0));

  // R6
  flags_kept_chk: assert property (@(posedge clk) disable iff (rst)
    !out_ready |=> (($past(pend) & ~pend) == '0));

  // R6
  output_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=>
      (out_valid && $stable(out_byte) && $stable(out_port) && $stable(out_chan)));

  // R2
  pending_served_chk: assert property (@(posedge clk) disable iff (rst)
    (out_ready && (pend != '0)) |-> (grant != '0));

  // R5
  drop_step_chk: assert property (@(posedge clk) disable iff (rst)
    ##1 ((drop_count == $past(drop_count)) ||
         (drop_count == CNT_W'($past(drop_count) + 1'b1))));
endmodule

bind port_byte_collector pbc_chk #(
  .NUM_PORTS(NUM_PORTS), .DATA_W(DATA_W), .CNT_W(CNT_W),
  .PORT_W(PORT_W), .CHAN_W(pbc_pkg::CHAN_W)
) u_chk (
  .clk(clk), .rst(rst), .out_ready(out_ready), .out_valid(out_valid),
  .out_byte(out_byte), .out_port(out_port), .out_chan(out_chan),
  .pend(pend), .grant(grant), .drop_count(drop_count)
);

// File: tb/sim_port_byte_collector.sv
module sim_port_byte_collector;
  logic         clk = 1'b0;
  logic         rst;
  logic [31:0]  port_load;
  logic [255:0] port_data;
  logic [159:0] port_ts;
  logic         map_we;
  logic [9:0]   map_addr;
  logic [7:0]   map_wdata;
  logic         out_ready;
  logic         out_valid;
  logic [7:0]   out_byte;
  logic [4:0]   out_port;
  logic [4:0]   out_ts;
  logic [4:0]   out_chan;
  logic [1:0]   out_ctype;
  logic [15:0]  drop_count;

  int n_tests = 0;
  int n_fail  = 0;
  logic [15:0] exp_drops = '0;

  always #10 clk = ~clk;

  port_byte_collector u0 (
    .clk(clk), .rst(rst), .port_load(port_load), .port_data(port_data),
    .port_ts(port_ts), .map_we(map_we), .map_addr(map_addr),
    .map_wdata(map_wdata), .out_ready(out_ready), .out_valid(out_valid),
    .out_byte(out_byte), .out_port(out_port), .out_ts(out_ts),
    .out_chan(out_chan), .out_ctype(out_ctype), .drop_count(drop_count)
  );

  // {port[4:0], ts[4:0], byte[7:0], map entry[7:0]}; entry = {en, type, chan}
  localparam logic [25:0] VEC [0:5] = '{
    {5'd0,  5'd0,  8'hA5, 8'hA3},
    {5'd31, 5'd31, 8'h3C, 8'hDF},
    {5'd12, 5'd7,  8'h00, 8'h80},
    {5'd5,  5'd17, 8'hFF, 8'h65},
    {5'd18, 5'd2,  8'h5A, 8'hF2},
    {5'd9,  5'd30, 8'h81, 8'h09}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic write_map(input logic [9:0] a, input logic [7:0] d);
    map_we = 1'b1; map_addr = a; map_wdata = d;
    @(negedge clk);
    map_we = 1'b0;
  endtask

  task automatic set_port(input int p, input logic [4:0] ts, input logic [7:0] b);
    port_load[p] = 1'b1;
    port_data[p*8 +: 8] = b;
    port_ts[p*5 +: 5] = ts;
  endtask

  task automatic expect_out(input string req, input logic [4:0] p, input logic [7:0] b,
                            input logic [4:0] ch);
    chk(req, {31'd0, out_valid}, 32'd1);
    chk(req, {27'd0, out_port}, {27'd0, p});
    chk(req, {24'd0, out_byte}, {24'd0, b});
    chk(req, {27'd0, out_chan}, {27'd0, ch});
  endtask

  initial begin
    #(200000 * 20);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    rst = 1'b1; port_load = '0; port_data = '0; port_ts = '0;
    map_we = 1'b0; map_addr = '0; map_wdata = '0; out_ready = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 valid in reset", {31'd0, out_valid}, 32'd0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 valid after reset", {31'd0, out_valid}, 32'd0);
    chk("R1 drops after reset", {16'd0, drop_count}, 32'd0);

    // table walk: R2, R4, R5
    for (int i = 0; i < 6; i++) begin
      logic [4:0] vp; logic [4:0] vt; logic [7:0] vb; logic [7:0] ve;
      {vp, vt, vb, ve} = VEC[i];
      write_map({vp, vt}, ve);
      set_port(int'(vp), vt, vb);
      @(negedge clk); port_load = '0;
      @(negedge clk);
      @(negedge clk);
      if (!ve[7]) exp_drops++;
      chk("R5 valid vs enable", {31'd0, out_valid}, {31'd0, ve[7]});
      chk("R5 drop count", {16'd0, drop_count}, {16'd0, exp_drops});
      if (ve[7]) begin
        chk("R2 byte", {24'd0, out_byte}, {24'd0, vb});
        chk("R4 port", {27'd0, out_port}, {27'd0, vp});
        chk("R4 ts", {27'd0, out_ts}, {27'd0, vt});
        chk("R4 chan", {27'd0, out_chan}, {27'd0, ve[4:0]});
        chk("R4 type", {30'd0, out_ctype}, {30'd0, ve[6:5]});
      end
      @(negedge clk);
      chk("R2 one cycle", {31'd0, out_valid}, 32'd0);
    end

    // R3: simultaneous ports come out lowest first
    write_map({5'd3, 5'd1}, 8'h83);
    write_map({5'd7, 5'd1}, 8'h87);
    write_map({5'd20, 5'd1}, 8'h94);
    set_port(7, 5'd1, 8'h77); set_port(3, 5'd1, 8'h33); set_port(20, 5'd1, 8'h14);
    @(negedge clk); port_load = '0;
    @(negedge clk);
    @(negedge clk); expect_out("R3 first", 5'd3, 8'h33, 5'd3);
    @(negedge clk); expect_out("R3 second", 5'd7, 8'h77, 5'd7);
    @(negedge clk); expect_out("R3 third", 5'd20, 8'h14, 5'd20);
    @(negedge clk); chk("R3 drained", {31'd0, out_valid}, 32'd0);

    // R6: stalled output holds, pipeline resumes
    write_map({5'd2, 5'd0}, 8'h82);
    write_map({5'd4, 5'd0}, 8'h84);
    set_port(2, 5'd0, 8'h22); set_port(4, 5'd0, 8'h44);
    @(negedge clk); port_load = '0;
    @(negedge clk);
    @(negedge clk); expect_out("R6 before stall", 5'd2, 8'h22, 5'd2);
    out_ready = 1'b0;
    repeat (3) @(negedge clk);
    expect_out("R6 held", 5'd2, 8'h22, 5'd2);
    out_ready = 1'b1;
    @(negedge clk); expect_out("R6 resumed", 5'd4, 8'h44, 5'd4);
    @(negedge clk); chk("R6 drained", {31'd0, out_valid}, 32'd0);

    // R6: byte pending while stalled is kept
    write_map({5'd9, 5'd3}, 8'h89);
    out_ready = 1'b0;
    set_port(9, 5'd3, 8'h99);
    @(negedge clk); port_load = '0;
    repeat (4) @(negedge clk);
    chk("R6 nothing while stalled", {31'd0, out_valid}, 32'd0);
    out_ready = 1'b1;
    @(negedge clk);
    @(negedge clk); expect_out("R6 kept flag", 5'd9, 8'h99, 5'd9);

    // R7: reload while pending keeps the newest byte only
    write_map({5'd6, 5'd4}, 8'h86);
    out_ready = 1'b0;
    set_port(6, 5'd4, 8'h11);
    @(negedge clk); port_load = '0;
    set_port(6, 5'd4, 8'h2B);
    @(negedge clk); port_load = '0;
    out_ready = 1'b1;
    @(negedge clk);
    @(negedge clk); expect_out("R7 newest", 5'd6, 8'h2B, 5'd6);
    @(negedge clk); chk("R7 single", {31'd0, out_valid}, 32'd0);

    // R7: load on the grant edge stays pending
    write_map({5'd10, 5'd5}, 8'h8A);
    set_port(10, 5'd5, 8'hA1);
    @(negedge clk);
    set_port(10, 5'd5, 8'hB2);
    @(negedge clk); port_load = '0;
    @(negedge clk); expect_out("R7 first of pair", 5'd10, 8'hA1, 5'd10);
    @(negedge clk); expect_out("R7 second of pair", 5'd10, 8'hB2, 5'd10);

    // R8: rewrite a map entry
    write_map({5'd0, 5'd0}, 8'h9E);
    set_port(0, 5'd0, 8'h5E);
    @(negedge clk); port_load = '0;
    @(negedge clk);
    @(negedge clk);
    expect_out("R8 remap", 5'd0, 8'h5E, 5'd30);
    chk("R8 type", {30'd0, out_ctype}, 32'd0);

    // R1: reset drops pending bytes
    out_ready = 1'b0;
    set_port(1, 5'd0, 8'h01);
    write_map({5'd1, 5'd0}, 8'h81);
    port_load = '0;
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0; out_ready = 1'b1;
    @(negedge clk);
    chk("R1 drops cleared", {16'd0, drop_count}, 32'd0);
    repeat (3) begin
      @(negedge clk);
      chk("R1 pending cleared", {31'd0, out_valid}, 32'd0);
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule